// File: doc/BRIEF.md
# ATM Cell Receive Port with Header Check

This block is the receive side of a byte-wide, single-device cell-bus port. An upstream source raises a cell-available line when it has a cell to send. The port answers by pulling an active-low enable low. Bytes then move one per clock, but only in cycles where the enable is low and the source still signals availability. A start-of-cell marker that is high only on the first byte aligns the port to the cell boundary. Bytes that arrive while the port is not aligned are dropped. The port builds each 53-byte cell in a buffer.

While the first four header bytes arrive, the port runs a CRC-8 over them. The polynomial is x^8+x^2+x+1, the initial value is zero, and the bytes are taken in arrival order. The remainder is XORed with 0x55 and compared with the fifth byte. When the last byte lands, the port issues a one-cycle valid pulse with an error flag and presents the whole cell. It then holds that cell, with the enable high, until downstream logic consumes it with a take strobe.

Top module: `atm_cell_rx`

## Requirements
- R1: After reset, `rx_en_n` is high and `cell_valid` is low.
- R2: `rx_en_n` is a registered output. It goes low in the cycle after `rx_clav` is seen high while no cell is held, and it is high while `rx_clav` is low.
- R3: A byte is accepted at a rising edge only when `rx_en_n` is low and `rx_clav` is high. A byte the source holds during enable-high cycles is taken exactly once.
- R4: While the port is idle (at byte position 0), an accepted byte with `rx_soc` low is discarded and produces no cell.
- R5: An accepted byte with `rx_soc` high becomes byte 0. The following 52 accepted bytes fill positions 1 to 52, and byte k appears on `cell_data[8k+7:8k]`. `cell_valid` is high for exactly the one cycle after the edge that accepts byte 52.
- R6: `hec_err` is valid with `cell_valid`. It is 1 when byte 4 differs from CRC-8 (polynomial 0x07, initial value 0, bytes 0,1,2,3 in that order, most significant bit first) XOR 0x55, and 0 otherwise.
- R7: An accepted byte with `rx_soc` high at any position other than 0 drops the partial cell and restarts assembly with that byte as byte 0.
- R8: While a completed cell is held, `rx_en_n` stays high, `cell_data` stays unchanged and no further cell is reported.
- R9: `cell_take` high while a cell is held releases the buffer at that clock edge. `rx_en_n` may go low at the next edge if `rx_clav` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data | input | 8 | Byte from the cell source |
| rx_soc | input | 1 | Start-of-cell marker, high with byte 0 |
| rx_clav | input | 1 | Source has cell data available |
| rx_en_n | output | 1 | Active-low transfer enable to the source |
| cell_take | input | 1 | Downstream consumes the held cell |
| cell_valid | output | 1 | One-cycle pulse: a complete cell is on `cell_data` |
| hec_err | output | 1 | Header check mismatch for the reported cell |
| cell_data | output | 424 | Assembled cell, byte k at bits 8k+7..8k |

## Verification
The assertions assume a source that keeps its byte and marker steady through enable-high cycles. They also assume downstream logic asserts `cell_take` only after it has seen a valid pulse. The bench source model drives data at the falling edge and reads the registered enable just after it. It advances to the next byte only when the enable was low for the coming rising edge. Its consumer raises the take strobe only after a pulse has been observed, or later when it holds the cell on purpose. The stimulus mixes random cells, cells with a corrupted header byte, truncated cells restarted by a new marker, stray bytes without a marker, and a long period in which the buffer is held while the source has the next cell ready.

// File: rtl/atm_rx_pkg.sv
package atm_rx_pkg;
  localparam int unsigned BYTE_W = 8;

  // One byte of a bitwise CRC-8, most significant bit first.
  function automatic logic [BYTE_W-1:0] crc8_byte(
    input logic [BYTE_W-1:0] crc,
    input logic [BYTE_W-1:0] din,
    input logic [BYTE_W-1:0] poly
  );
    logic [BYTE_W-1:0] r;
    r = crc ^ din;
    for (int b = 0; b < BYTE_W; b++) begin
      r = r[BYTE_W-1] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

  // Expected header check byte from the running remainder.
  function automatic logic [BYTE_W-1:0] hec_from_crc(
    input logic [BYTE_W-1:0] crc,
    input logic [BYTE_W-1:0] coset
  );
    return crc ^ coset;
  endfunction
endpackage

// File: rtl/cell_framer.sv
module cell_framer #(
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned IDX_W    = $clog2(CELL_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer,
  input  logic             soc,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             cell_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  logic [IDX_W-1:0] pos_q;
  logic             start_ev;
  logic             busy;

  assign busy      = (pos_q != '0);
  assign start_ev  = xfer && soc;
  assign wr_en     = xfer && (soc || busy);
  assign wr_idx    = soc ? '0 : pos_q;
  assign cell_last = wr_en && (wr_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (start_ev) begin
      pos_q <= IDX_ONE;
    end else if (wr_en) begin
      pos_q <= cell_last ? '0 : pos_q + IDX_ONE;
    end
  end

  // R7: a marker always restarts assembly at position 1 next
  assert_soc_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && soc) |=> (pos_q == IDX_ONE));

  // R4: unmarked bytes while idle leave the framer idle
  assert_idle_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !soc && !busy) |=> (pos_q == '0));
endmodule

// File: rtl/hec_checker.sv
module hec_checker
  import atm_rx_pkg::*;
#(
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned HDR_LEN = 4,
  parameter logic [7:0]  POLY    = 8'h07,
  parameter logic [7:0]  COSET   = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       din,
  output logic             hec_bad
);
  localparam logic [IDX_W-1:0] HEC_IDX = IDX_W'(HDR_LEN);

  logic [7:0] crc_q;
  logic       bad_q;
  logic       hdr_byte;
  logic       chk_byte;
  logic [7:0] crc_seed;

  assign hdr_byte = wr_en && (wr_idx < HEC_IDX);
  assign chk_byte = wr_en && (wr_idx == HEC_IDX);
  assign crc_seed = (wr_idx == '0) ? 8'h00 : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= '0;
      bad_q <= 1'b0;
    end else begin
      if (hdr_byte) begin
        crc_q <= crc8_byte(crc_seed, din, POLY);
      end
      if (chk_byte) begin
        bad_q <= (hec_from_crc(crc_q, COSET) != din);
      end else if (wr_en && wr_idx == '0) begin
        bad_q <= 1'b0;
      end
    end
  end

  assign hec_bad = bad_q;

  // R6: the verdict only moves on a check byte or a new cell start
  assert_verdict_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bad_q));
endmodule

// File: rtl/cell_store.sv
module cell_store #(
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned IDX_W    = $clog2(CELL_LEN),
  parameter int unsigned DATA_W   = CELL_LEN * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        din,
  input  logic              cell_last,
  input  logic              hec_bad,
  input  logic              take,
  input  logic              clav,
  output logic [DATA_W-1:0] cell_data,
  output logic              valid,
  output logic              err,
  output logic              held,
  output logic              en_n
);
  logic [7:0] byte_q [CELL_LEN];
  logic       full_q, full_d;
  logic       valid_q, err_q, en_n_q;
  logic       release_ev;

  for (genvar g = 0; g < CELL_LEN; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byte_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        byte_q[g] <= din;
      end
    end
    assign cell_data[g*8 +: 8] = byte_q[g];
  end

  assign release_ev = full_q && take;

  always_comb begin
    full_d = full_q;
    if (cell_last)       full_d = 1'b1;
    else if (release_ev) full_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      en_n_q  <= 1'b1;
    end else begin
      full_q  <= full_d;
      valid_q <= cell_last;
      en_n_q  <= !(clav && !full_d);
      if (cell_last) err_q <= hec_bad;
    end
  end

  assign valid = valid_q;
  assign err   = err_q;
  assign held  = full_q;
  assign en_n  = en_n_q;

  // R8: a held cell keeps the source stopped
  assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> en_n_q);

  // R3: nothing is written while a cell is held
  assert_no_write_when_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !wr_en);

  // R5: the valid pulse lasts one cycle
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R9: a take on a held cell frees the buffer
  assert_take_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && take) |=> !full_q);
endmodule

// File: rtl/atm_cell_rx.sv
module atm_cell_rx
  import atm_rx_pkg::*;
#(
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned HDR_LEN  = 4,
  parameter logic [7:0]  POLY     = 8'h07,
  parameter logic [7:0]  COSET    = 8'h55,
  localparam int unsigned IDX_W   = $clog2(CELL_LEN),
  localparam int unsigned DATA_W  = CELL_LEN * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_data,
  input  logic              rx_soc,
  input  logic              rx_clav,
  output logic              rx_en_n,
  input  logic              cell_take,
  output logic              cell_valid,
  output logic              hec_err,
  output logic [DATA_W-1:0] cell_data
);
  // Internal events, named for the checks
  logic             xfer;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             cell_last;
  logic             hec_bad;
  logic             held;

  assign xfer = !rx_en_n && rx_clav;

  cell_framer #(.CELL_LEN(CELL_LEN), .IDX_W(IDX_W)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer     (xfer),
    .soc      (rx_soc),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .cell_last(cell_last)
  );

  hec_checker #(.IDX_W(IDX_W), .HDR_LEN(HDR_LEN), .POLY(POLY), .COSET(COSET)) u_hec (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .din    (rx_data),
    .hec_bad(hec_bad)
  );

  cell_store #(.CELL_LEN(CELL_LEN), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .din      (rx_data),
    .cell_last(cell_last),
    .hec_bad  (hec_bad),
    .take     (cell_take),
    .clav     (rx_clav),
    .cell_data(cell_data),
    .valid    (cell_valid),
    .err      (hec_err),
    .held     (held),
    .en_n     (rx_en_n)
  );

  // R2: with no cell available the enable is high one cycle later
  assert_clav_low_disables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_clav |=> rx_en_n);

  // R5: a completed cell is reported on the next cycle
  assert_last_reports_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cell_last |=> (cell_valid && held));
endmodule

// File: tb/tb_atm_cell_rx.sv
`timescale 1ns/1ps
module tb_atm_cell_rx;
  localparam int LEN = 53;
  localparam int W   = LEN * 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   rx_data = '0;
  logic         rx_soc = 1'b0;
  logic         rx_clav = 1'b0;
  logic         cell_take = 1'b0;
  logic         rx_en_n;
  logic         cell_valid;
  logic         hec_err;
  logic [W-1:0] cell_data;

  always #2.5 clk = ~clk;

  atm_cell_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_soc(rx_soc),
    .rx_clav(rx_clav), .rx_en_n(rx_en_n), .cell_take(cell_take),
    .cell_valid(cell_valid), .hec_err(hec_err), .cell_data(cell_data)
  );

  int total = 0;
  int bad = 0;
  int got = 0;
  int sent = 0;
  bit hold = 1'b0;
  bit pend = 1'b0;
  logic [W-1:0] expq[$];
  bit           errq[$];

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Long division of header||00000000 by 0x107, then the coset.
  function automatic logic [7:0] ref_hec(input logic [31:0] hdr);
    logic [39:0] v;
    v = {hdr, 8'h00};
    for (int b = 39; b >= 8; b--) begin
      if (v[b]) v = v ^ (40'h107 << (b - 8));
    end
    return v[7:0] ^ 8'h55;
  endfunction

  function automatic logic [W-1:0] make_cell(input bit corrupt);
    logic [W-1:0] c;
    logic [31:0]  hdr;
    for (int k = 0; k < LEN; k++) c[k*8 +: 8] = 8'($urandom);
    hdr = {c[7:0], c[15:8], c[23:16], c[31:24]};
    c[39:32] = ref_hec(hdr) ^ (corrupt ? (8'h01 << ($urandom % 8)) : 8'h00);
    return c;
  endfunction

  // Source model: bytes change at the falling edge, advance only if taken.
  task automatic send_cell(input logic [W-1:0] c, input int n, input bit mark);
    logic e;
    @(negedge clk);
    rx_clav = 1'b1;
    for (int i = 0; i < n; ) begin
      rx_data = c[i*8 +: 8];
      rx_soc  = mark && (i == 0);
      #1 e = rx_en_n;
      @(negedge clk);
      if (!e) i++;
    end
    rx_clav = 1'b0;
    rx_soc  = 1'b0;
  endtask

  task automatic expect_cell(input logic [W-1:0] c, input bit is_bad);
    expq.push_back(c);
    errq.push_back(is_bad);
    sent++;
  endtask

  // Consumer / monitor
  initial begin
    forever begin
      @(negedge clk);
      cell_take = 1'b0;
      if (rst_n && cell_valid) begin
        got++;
        if (expq.size() == 0) begin
          check("R4", "unexpected cell (R7 restart or stray bytes)", W'(1), W'(0));
        end else begin
          logic [W-1:0] ec;
          bit ee;
          ec = expq.pop_front();
          ee = errq.pop_front();
          check("R5", "cell bytes", cell_data, ec);
          check("R6", "hec_err", W'(hec_err), W'(ee));
        end
        pend = 1'b1;
      end
      if (pend && !hold) begin
        cell_take = 1'b1;
        pend = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [W-1:0] c1, c2;
    int g0;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1", "rx_en_n after reset", W'(rx_en_n), W'(1));
    check("R1", "cell_valid after reset", W'(cell_valid), W'(0));
    repeat (3) @(negedge clk); #1;
    check("R2", "enable high with clav low", W'(rx_en_n), W'(1));

    // R2: raising availability lowers the enable one edge later
    @(negedge clk);
    rx_clav = 1'b1; rx_soc = 1'b0; rx_data = 8'hA5;
    #1 check("R2", "enable before edge", W'(rx_en_n), W'(1));
    @(negedge clk); #1;
    check("R2", "enable after edge", W'(rx_en_n), W'(0));
    rx_clav = 1'b0;
    repeat (2) @(negedge clk);

    // R4: stray bytes without a marker
    c1 = make_cell(1'b0);
    send_cell(c1, 5, 1'b0);
    repeat (3) @(negedge clk);
    check("R4", "no cell from stray bytes", W'(got), W'(0));

    // R5/R6: one good and one corrupted header
    c1 = make_cell(1'b0); expect_cell(c1, 1'b0); send_cell(c1, LEN, 1'b1);
    c1 = make_cell(1'b1); expect_cell(c1, 1'b1); send_cell(c1, LEN, 1'b1);

    // R7: truncated cells restarted by a new marker
    c1 = make_cell(1'b0); send_cell(c1, 20, 1'b1);
    c2 = make_cell(1'b0); expect_cell(c2, 1'b0); send_cell(c2, LEN, 1'b1);
    c1 = make_cell(1'b0); send_cell(c1, LEN - 1, 1'b1);
    c2 = make_cell(1'b1); expect_cell(c2, 1'b1); send_cell(c2, LEN, 1'b1);
    repeat (3) @(negedge clk);
    check("R7", "cells after restarts", W'(got), W'(4));

    // R8/R9/R3: hold the buffer while the next cell waits
    hold = 1'b1;
    c1 = make_cell(1'b0); expect_cell(c1, 1'b0); send_cell(c1, LEN, 1'b1);
    repeat (2) @(negedge clk);
    g0 = got;
    c2 = make_cell(1'b0); expect_cell(c2, 1'b0);
    fork
      send_cell(c2, LEN, 1'b1);
    join_none
    repeat (40) @(negedge clk); #1;
    check("R8", "enable held high", W'(rx_en_n), W'(1));
    check("R8", "no new cell while held", W'(got), W'(g0));
    check("R8", "held data stable", cell_data, c1);
    hold = 1'b0;
    wait fork;
    repeat (3) @(negedge clk);
    check("R9", "cell after release", W'(got), W'(g0 + 1));
    check("R3", "queue drained after held source", W'(expq.size()), W'(0));

    // Random traffic
    for (int n = 0; n < 20; n++) begin
      bit cb;
      cb = ($urandom % 4) == 0;
      c1 = make_cell(cb);
      expect_cell(c1, cb);
      send_cell(c1, LEN, 1'b1);
      repeat ($urandom % 5) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check("R5", "all expected cells seen", W'(expq.size()), W'(0));
    check("R4", "cell count", W'(got), W'(sent));
    finish_up();
  end
endmodule